// File: doc/BRIEF.md
# Exception Priority Sequencer With Trace

This block sits at the end of the instruction pipeline and decides in which order the exception conditions raised around one instruction are serviced. When an instruction finishes, it captures the pending conditions: a forced exception, an illegal, unimplemented or privileged instruction, a trace request, a pending breakpoint and a pending interrupt. It then hands them to the exception entry logic one at a time, using a valid/acknowledge handshake.

The trace request is qualified by the trace enable bit as it stood when the instruction began. An instruction that never executes, because it is illegal, produces no trace. A stop instruction normally leaves the core in the stopped state once the status register has been loaded. If tracing was on when the stop instruction began, the core takes the trace exception instead, and the stopped state is not entered.

Top module: `exc_trace_seq`

## Requirements
- R1: After reset, grant_valid_o and stopped_o are low.
- R2: An instruction ending with forced_i or illegal_i high produces a grant with code 0 (forced) as its first grant.
- R3: A trace grant (code 1) is produced when trace_en_i was high in the cycle insn_start_i was high, and illegal_i is low at completion. Changes to trace_en_i after that start cycle have no effect on the instruction.
- R4: An instruction ending with illegal_i high produces no trace grant, whatever the trace enable state.
- R5: Grants from one instruction come out in strictly increasing code order: forced (0), trace (1), breakpoint (2), interrupt (3). Each pending condition is granted exactly once.
- R6: grant_valid_o rises in the cycle after insn_done_i. A grant holds its code until grant_ack_i is high at a clock edge. The next grant, if any, is shown in the following cycle.
- R7: An instruction ending with stop_i high, illegal_i low and no trace request raises stopped_o in the cycle after insn_done_i. stopped_o stays high until the next insn_start_i.
- R8: A stop instruction begun with trace enabled produces a trace grant and leaves stopped_o low.
- R9: insn_done_i asserted while a grant is outstanding is ignored. No grant is added from it.
- R10: insn_done_i with no condition pending produces no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_start_i | input | 1 | Instruction begins; trace enable is sampled |
| trace_en_i | input | 1 | Trace enable bit from the status register |
| insn_done_i | input | 1 | Instruction completion strobe |
| illegal_i | input | 1 | Instruction illegal, unimplemented or privileged |
| forced_i | input | 1 | Instruction forced an exception |
| bkpt_i | input | 1 | Breakpoint pending at completion |
| irq_i | input | 1 | Interrupt pending at completion |
| stop_i | input | 1 | Completed instruction is a stop instruction |
| grant_ack_i | input | 1 | Exception entry logic accepts the shown grant |
| grant_valid_o | output | 1 | A grant is shown |
| grant_code_o | output | 2 | Grant kind: 0 forced, 1 trace, 2 breakpoint, 3 interrupt |
| stopped_o | output | 1 | Core should stay in the stopped state |

## Verification
Some properties are checked on every cycle. An unacknowledged grant holds its code. Codes within one sequence only increase. An illegal completion always leads with a forced grant. stopped_o never coincides with a trace grant and falls after a new start. Other behaviour can only be shown by the bench's scenarios. These include the exact set of grants for each of the 64 combinations of trace enable, illegal, forced, breakpoint, interrupt and stop, compared with an ordering model. They also include the sampling of trace enable at the start cycle rather than at completion, and the dropping of a completion that arrives while a grant is outstanding.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned CODE_W  = $clog2(NUM_SRC);

  typedef enum logic [CODE_W-1:0] {
    EXC_FORCED = 2'd0,
    EXC_TRACE  = 2'd1,
    EXC_BKPT   = 2'd2,
    EXC_IRQ    = 2'd3
  } exc_kind_e;
endpackage

// File: rtl/exc_trace_qual.sv
module exc_trace_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic trace_en_i,
  input  logic illegal_i,
  output logic trace_req_o
);
  logic t1_q;
  logic t1_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      t1_q <= 1'b0;
    else if (start_i) t1_q <= trace_en_i;
  end

  // single-cycle instruction: start and done coincide
  assign t1_eff      = start_i ? trace_en_i : t1_q;
  assign trace_req_o = t1_eff & ~illegal_i;
endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int unsigned N = 4,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [N-1:0] onehot_o,
  output logic [W-1:0] idx_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign onehot_o[i] = req_i[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | req_i[i];
  end

  assign any_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot_o[i]) idx_o = idx_o | W'(i);
    end
  end
endmodule

// File: rtl/exc_stop_ctl.sv
module exc_stop_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic illegal_i,
  input  logic trace_req_i,
  output logic stopped_o
);
  logic stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      stop_q <= 1'b0;
    else if (accept_i && stop_i && !illegal_i && !trace_req_i)
      stop_q <= 1'b1;
    else if (start_i)
      stop_q <= 1'b0;
  end

  assign stopped_o = stop_q;
endmodule

// File: rtl/exc_trace_seq.sv
module exc_trace_seq
  import exc_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              insn_start_i,
  input  logic              trace_en_i,
  input  logic              insn_done_i,
  input  logic              illegal_i,
  input  logic              forced_i,
  input  logic              bkpt_i,
  input  logic              irq_i,
  input  logic              stop_i,
  input  logic              grant_ack_i,
  output logic              grant_valid_o,
  output logic [CODE_W-1:0] grant_code_o,
  output logic              stopped_o
);
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] pend_new;
  logic [NUM_SRC-1:0] pick_oh;
  logic               pend_any;
  logic               trace_req;
  logic               accept;

  exc_trace_qual u_trace (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (insn_start_i),
    .trace_en_i (trace_en_i),
    .illegal_i  (illegal_i),
    .trace_req_o(trace_req)
  );

  // bit index equals grant code: lower index wins
  always_comb begin
    pend_new             = '0;
    pend_new[EXC_FORCED] = forced_i | illegal_i;
    pend_new[EXC_TRACE]  = trace_req;
    pend_new[EXC_BKPT]   = bkpt_i;
    pend_new[EXC_IRQ]    = irq_i;
  end

  exc_prio_pick #(.N(NUM_SRC)) u_pick (
    .req_i   (pend_q),
    .any_o   (pend_any),
    .onehot_o(pick_oh),
    .idx_o   (grant_code_o)
  );

  assign accept = insn_done_i & ~pend_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     pend_q <= '0;
    else if (accept)                 pend_q <= pend_new;
    else if (grant_ack_i && pend_any) pend_q <= pend_q & ~pick_oh;
  end

  assign grant_valid_o = pend_any;

  exc_stop_ctl u_stop (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .start_i    (insn_start_i),
    .stop_i     (stop_i),
    .illegal_i  (illegal_i),
    .trace_req_i(trace_req),
    .stopped_o  (stopped_o)
  );
endmodule

// File: rtl/exc_trace_seq_chk.sv
module exc_trace_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       insn_start_i,
  input logic       insn_done_i,
  input logic       illegal_i,
  input logic       grant_ack_i,
  input logic       grant_valid_o,
  input logic [1:0] grant_code_o,
  input logic       stopped_o
);
  a_r6_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o && !grant_ack_i |=> grant_valid_o && $stable(grant_code_o));

  a_r5_rising_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o && grant_ack_i |=> !grant_valid_o || (grant_code_o > $past(grant_code_o)));

  a_r2_illegal_leads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_done_i && illegal_i && !grant_valid_o |=> grant_valid_o && grant_code_o == 2'd0);

  a_r8_no_trace_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped_o |-> !(grant_valid_o && grant_code_o == 2'd1));

  a_r7_start_clears_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_start_i && !insn_done_i |=> !stopped_o);

  a_r10_idle_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_valid_o && !insn_done_i |=> !grant_valid_o);
endmodule

bind exc_trace_seq exc_trace_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .insn_start_i (insn_start_i),
  .insn_done_i  (insn_done_i),
  .illegal_i    (illegal_i),
  .grant_ack_i  (grant_ack_i),
  .grant_valid_o(grant_valid_o),
  .grant_code_o (grant_code_o),
  .stopped_o    (stopped_o)
);

// File: tb/exc_trace_seq_tb.sv
module exc_trace_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, t1 = 0, done = 0, ill = 0, frc = 0, bkp = 0, irq = 0, stp = 0, ack = 0;
  logic       gvalid;
  logic [1:0] gcode;
  logic       stopped;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  exc_trace_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .insn_start_i(start), .trace_en_i(t1),
    .insn_done_i(done), .illegal_i(ill), .forced_i(frc), .bkpt_i(bkp),
    .irq_i(irq), .stop_i(stp), .grant_ack_i(ack),
    .grant_valid_o(gvalid), .grant_code_o(gcode), .stopped_o(stopped)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(!gvalid, "R1 valid", gvalid, 0);
    chk(!stopped, "R1 stopped", stopped, 0);
  endtask

  // combo bits: 0 t1, 1 illegal, 2 forced, 3 bkpt, 4 irq, 5 stop
  task automatic test_combo(input int c);
    bit c_t1, c_il, c_fr, c_bk, c_iq, c_st, exp_stop;
    int exp_q[4];
    int n, got;
    c_t1 = c[0]; c_il = c[1]; c_fr = c[2]; c_bk = c[3]; c_iq = c[4]; c_st = c[5];
    n = 0;
    if (c_fr || c_il)  exp_q[n++] = 0;
    if (c_t1 && !c_il) exp_q[n++] = 1;
    if (c_bk)          exp_q[n++] = 2;
    if (c_iq)          exp_q[n++] = 3;
    exp_stop = c_st && !c_il && !c_t1;

    @(negedge clk); start = 1; t1 = c_t1;
    @(negedge clk); start = 0; t1 = !c_t1; // R3: later changes must not matter
    chk(!stopped, "R7 cleared by start", stopped, 0);
    @(negedge clk); done = 1; ill = c_il; frc = c_fr; bkp = c_bk; irq = c_iq; stp = c_st;
    @(negedge clk); done = 0; ill = 0; frc = 0; bkp = 0; irq = 0; stp = 0;
    chk(stopped == exp_stop, (c_st && c_t1) ? "R8 trace cancels stop" : "R7 stop entry",
        stopped, exp_stop);
    got = 0;
    while (gvalid && got < 5) begin
      if (got < n)
        chk(gcode == exp_q[got], (got == 0 && (c_fr || c_il)) ? "R2 forced first" : "R5 order",
            gcode, exp_q[got]);
      else
        chk(0, "R5 extra grant", gcode, -1);
      if (c_il) chk(gcode != 2'd1, "R4 illegal no trace", gcode, 0);
      @(negedge clk);
      chk(gvalid && gcode == exp_q[got % 4], "R6 hold without ack", gcode, exp_q[got % 4]);
      ack = 1;
      @(negedge clk); ack = 0;
      got++;
    end
    chk(got == n, (n == 0) ? "R10 no grant" : "R5 grant count", got, n);
    if (c_t1 && !c_il)
      chk(got > 0, "R3 trace from start sample", got, n);
  endtask

  task automatic test_done_while_busy();
    @(negedge clk); start = 1; t1 = 0;
    @(negedge clk); start = 0;
    @(negedge clk); done = 1; irq = 1;
    @(negedge clk); done = 0; irq = 0;
    chk(gvalid && gcode == 2'd3, "R6 irq grant", gcode, 3);
    done = 1; frc = 1; bkp = 1;
    @(negedge clk); done = 0; frc = 0; bkp = 0;
    chk(gvalid && gcode == 2'd3, "R9 busy done ignored", gcode, 3);
    ack = 1;
    @(negedge clk); ack = 0;
    chk(!gvalid, "R9 nothing queued", gvalid, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        test_reset();
        for (int c = 0; c < 64; c++) test_combo(c);
        test_done_while_busy();
      end
      begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule